// File: doc/BRIEF.md
# Timer Frame Access Controller

This block is the control frame that sits in front of a group of up to eight memory-mapped timer frames. It gives software one identification word that tells which frames carry a virtual timer. It also gives one permission register per frame, and that register decides which counter and timer features the frame exposes. Each permission register drives a six-bit permission vector straight to its timer frame.

A permission register keeps only the bits its frame can honour. Software finds out what a frame can do by writing all ones to the register and reading it back. Every permission starts cleared after reset, so a frame exposes nothing until software grants it. Access goes through a plain 32-bit register port made of an address, a write strobe, write data and registered read data.

Top module: `timer_frame_acl`

## Requirements
- R1: After a synchronous reset, every permission register, every `perm_o` bit and `bus_rdata` read as zero.
- R2: A read of byte offset 0x08 returns the identification word. For each frame n below NUM_FRAMES, bit 4n+1 equals VIRT_CAP[n]. Every other bit is zero. A write to 0x08 has no effect on any register or output.
- R3: The permission register of frame n sits at byte offset 0x40 + 4n. A write there stores the write data masked by the frame's support mask. The six bits mean: bit 0 physical count read, bit 1 virtual count read, bit 2 frequency read, bit 3 virtual offset read, bit 4 virtual timer write, bit 5 physical timer write. A frame with VIRT_CAP[n]=1 supports all six bits (mask 0x3F).
- R4: For a frame with VIRT_CAP[n]=0, bits 1, 3 and 4 are tied to zero and always read zero (mask 0x25). Writing all ones to such a frame reads back 0x25.
- R5: Bits 31:6 of every permission register read zero, whatever value was written.
- R6: A read of any offset that is neither 0x08 nor a word-aligned 0x40 + 4n with n < NUM_FRAMES returns zero. A write to such an offset changes no register and no output.
- R7: `perm_o[6n+5:6n]` always equals frame n's permission register. It takes a new value on the same clock edge that performs the write.
- R8: `bus_rdata` is registered. It shows the addressed register one cycle after the address is presented. When a read and a write hit the same register in that cycle, it shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address presented in the previous cycle |
| perm_o | output | NUM_FRAMES*6 | Concatenated per-frame permission vectors, frame 0 in the low bits |

## Verification
The assertions check four things on every cycle:
- the tied-zero bits of frames without a virtual timer, which must always read zero;
- that the permission outputs never move in a cycle without a write;
- that read data for the identification word, for unmapped offsets and for the upper register bits follows the address from the cycle before;
- that a permission read returns the value held before that edge.

Only the bench scenarios can show three other things:
- that each frame keeps exactly the masked value that was written, for all 64 patterns;
- that a sweep of writes over every unmapped offset leaves all frames untouched;
- that a write to one frame never disturbs another.

// File: rtl/tfac_pkg.sv
package tfac_pkg;

  localparam int DATA_W       = 32;
  localparam int PERM_W       = 6;
  localparam int ID_OFFSET    = 8;
  localparam int ACR_BASE     = 64;
  localparam int ID_FIELD_W   = 4;
  localparam int ID_VIRT_POS  = 1;

  localparam int P_PHYS_CNT_RD = 0;
  localparam int P_VIRT_CNT_RD = 1;
  localparam int P_FREQ_RD     = 2;
  localparam int P_VOFF_RD     = 3;
  localparam int P_VIRT_TMR_WR = 4;
  localparam int P_PHYS_TMR_WR = 5;

  typedef logic [PERM_W-1:0] perm_t;

  localparam perm_t PERM_PHYS_ONLY = perm_t'((1 << P_PHYS_CNT_RD) |
                                             (1 << P_FREQ_RD)     |
                                             (1 << P_PHYS_TMR_WR));
  localparam perm_t PERM_ALL       = '1;

  function automatic perm_t support_mask(input logic has_virt);
    return has_virt ? PERM_ALL : PERM_PHYS_ONLY;
  endfunction

  function automatic logic [DATA_W-1:0] build_id(input logic [7:0] cap, input int nf);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int n = 0; n < 8; n++) begin
      if (n < nf) w[n*ID_FIELD_W + ID_VIRT_POS] = cap[n];
    end
    return w;
  endfunction

endpackage

// File: rtl/tfac_addr_dec.sv
module tfac_addr_dec #(
  parameter int NUM_FRAMES = 8,
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              id_hit,
  output logic              fr_hit,
  output logic [IDX_W-1:0]  fr_idx
);
  localparam int SLOT_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] ID_ADDR  = ADDR_W'(tfac_pkg::ID_OFFSET);
  localparam logic [ADDR_W-1:0] ACR_ADDR = ADDR_W'(tfac_pkg::ACR_BASE);
  localparam logic [SLOT_W-1:0] NF_SLOT  = SLOT_W'(NUM_FRAMES);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off    = addr - ACR_ADDR;
    id_hit = (addr == ID_ADDR);
    fr_hit = (addr >= ACR_ADDR) && (off[1:0] == 2'b00) &&
             (off[ADDR_W-1:2] < NF_SLOT);
    fr_idx = off[IDX_W+1:2];
  end

endmodule

// File: rtl/tfac_perm_reg.sv
module tfac_perm_reg #(
  parameter logic [5:0] SUPPORT = 6'h3F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [5:0] wdata,
  output logic [5:0] q
);
  for (genvar b = 0; b < 6; b++) begin : g_bit
    if (SUPPORT[b]) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)        q[b] <= 1'b0;
        else if (wr_en) q[b] <= wdata[b];
      end
    end else begin : g_tie
      assign q[b] = 1'b0;
    end
  end

endmodule

// File: rtl/tfac_rd_mux.sv
module tfac_rd_mux #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         id_hit,
  input  logic                         fr_hit,
  input  logic [IDX_W-1:0]             fr_idx,
  input  logic [31:0]                  id_word,
  input  logic [NUM_FRAMES-1:0][5:0]   perm,
  output logic [31:0]                  rdata
);
  logic [5:0]  sel_perm;
  logic [31:0] nxt;

  always_comb begin
    sel_perm = '0;
    for (int n = 0; n < NUM_FRAMES; n++) begin
      if (fr_idx == IDX_W'(n)) sel_perm = perm[n];
    end
    if (id_hit)      nxt = id_word;
    else if (fr_hit) nxt = {26'b0, sel_perm};
    else             nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end

endmodule

// File: rtl/timer_frame_acl.sv
module timer_frame_acl #(
  parameter int         NUM_FRAMES = 8,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] VIRT_CAP   = 8'hA6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [NUM_FRAMES*6-1:0]  perm_o
);
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam logic [31:0] ID_WORD = tfac_pkg::build_id(VIRT_CAP, NUM_FRAMES);

  logic                       id_hit;
  logic                       fr_hit;
  logic [IDX_W-1:0]           fr_idx;
  logic [NUM_FRAMES-1:0][5:0] perm_q;
  logic                       unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:6];

  tfac_addr_dec #(
    .NUM_FRAMES (NUM_FRAMES),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W)
  ) i_dec (
    .addr   (bus_addr),
    .id_hit (id_hit),
    .fr_hit (fr_hit),
    .fr_idx (fr_idx)
  );

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic wr_en;
    assign wr_en = bus_we && fr_hit && (fr_idx == IDX_W'(g));
    tfac_perm_reg #(
      .SUPPORT (tfac_pkg::support_mask(VIRT_CAP[g]))
    ) i_reg (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_en),
      .wdata (bus_wdata[5:0]),
      .q     (perm_q[g])
    );
  end

  tfac_rd_mux #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W)
  ) i_rd (
    .clk     (clk),
    .rst     (rst),
    .id_hit  (id_hit),
    .fr_hit  (fr_hit),
    .fr_idx  (fr_idx),
    .id_word (ID_WORD),
    .perm    (perm_q),
    .rdata   (bus_rdata)
  );

  assign perm_o = perm_q;

endmodule

// File: rtl/tfac_checker.sv
module tfac_checker #(
  parameter int         NUM_FRAMES = 8,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] VIRT_CAP   = 8'hA6
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_we,
  input logic [31:0]             bus_rdata,
  input logic [NUM_FRAMES*6-1:0] perm_o
);
  localparam logic [31:0] ID_EXP = tfac_pkg::build_id(VIRT_CAP, NUM_FRAMES);

  logic       c_id;
  logic       c_fr;
  logic [5:0] c_sel;

  always_comb begin
    c_id  = (int'(bus_addr) == tfac_pkg::ID_OFFSET);
    c_fr  = 1'b0;
    c_sel = '0;
    for (int n = 0; n < NUM_FRAMES; n++) begin
      if (int'(bus_addr) == tfac_pkg::ACR_BASE + 4*n) begin
        c_fr  = 1'b1;
        c_sel = perm_o[n*6 +: 6];
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (perm_o == '0 && bus_rdata == '0)); // R1

  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(c_id)) |-> bus_rdata == ID_EXP); // R2

  AST_PERM_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(c_fr)) |-> bus_rdata == {26'b0, $past(c_sel)}); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(c_id) |-> bus_rdata[31:6] == '0); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(c_id) && !$past(c_fr)) |-> bus_rdata == '0); // R6

  AST_PERM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_we)) |-> $stable(perm_o)); // R7

  for (genvar n = 0; n < NUM_FRAMES; n++) begin : g_tie
    if (!VIRT_CAP[n]) begin : g_nv
      AST_NOVIRT_TIED: assert property (@(posedge clk) disable iff (rst)
        (perm_o[n*6+1] == 1'b0 && perm_o[n*6+3] == 1'b0 && perm_o[n*6+4] == 1'b0)); // R4
    end
  end

endmodule

bind timer_frame_acl tfac_checker #(
  .NUM_FRAMES (NUM_FRAMES),
  .ADDR_W     (ADDR_W),
  .VIRT_CAP   (VIRT_CAP)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .perm_o    (perm_o)
);

// File: tb/test_timer_frame_acl.sv
module test_timer_frame_acl;
  localparam int         NF   = 8;
  localparam int         AW   = 8;
  localparam logic [7:0] VCAP = 8'hA6;

  logic              clk = 1'b0;
  logic              rst;
  logic [AW-1:0]     bus_addr;
  logic              bus_we;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NF*6-1:0]   perm_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] model [NF];

  always #5 clk = ~clk;

  timer_frame_acl #(.NUM_FRAMES(NF), .ADDR_W(AW), .VIRT_CAP(VCAP)) i_timer_frame_acl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .perm_o(perm_o)
  );

  function automatic logic [5:0] supp(input int n);
    return VCAP[n] ? 6'h3F : 6'h25;
  endfunction

  function automatic logic [31:0] id_exp();
    logic [31:0] w = '0;
    for (int n = 0; n < NF; n++) w[4*n+1] = VCAP[n];
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic chk_all_perm(input string req);
    for (int n = 0; n < NF; n++) chk(req, {26'b0, perm_o[n*6 +: 6]}, {26'b0, model[n]});
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; rst = 1'b1;
    for (int n = 0; n < NF; n++) model[n] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 perm_o", {{(80-NF*6){1'b0}}, perm_o} , '0);
    chk("R1 rdata", bus_rdata, '0);
    for (int n = 0; n < NF; n++) begin
      rd(64 + 4*n, r); chk("R1 reg", r, '0);
    end

    // R2: identification word, write ignored
    rd(8, r); chk("R2 id", r, id_exp());
    wr(8, 32'hFFFF_FFFF);
    rd(8, r); chk("R2 id after write", r, id_exp());
    chk_all_perm("R2 outputs after id write");

    // R3/R4/R5: all-ones probe per frame
    for (int n = 0; n < NF; n++) begin
      wr(64 + 4*n, 32'hFFFF_FFFF);
      model[n] = supp(n);
      rd(64 + 4*n, r);
      chk(VCAP[n] ? "R3 probe" : "R4 probe", r, {26'b0, supp(n)});
      chk("R5 upper", {26'b0, r[31:6]}, '0);
    end

    // R3/R4/R7: every pattern on every frame
    for (int n = 0; n < NF; n++) begin
      for (int p = 0; p < 64; p++) begin
        wr(64 + 4*n, {~26'b0, 6'(p)});
        model[n] = 6'(p) & supp(n);
        chk("R7 perm_o", {26'b0, perm_o[n*6 +: 6]}, {26'b0, model[n]});
        rd(64 + 4*n, r);
        chk(VCAP[n] ? "R3 pattern" : "R4 pattern", r, {26'b0, model[n]});
      end
      chk_all_perm("R7 isolation");
    end

    // R6: unmapped sweep with all frames loaded
    for (int n = 0; n < NF; n++) begin
      wr(64 + 4*n, 32'hFFFF_FFFF); model[n] = supp(n);
    end
    for (int a = 0; a < 256; a++) begin
      if (a == 8 || (a >= 64 && a < 64 + 4*NF && (a % 4) == 0)) continue;
      wr(a, 32'h0000_0000);
      rd(a, r); chk("R6 unmapped read", r, '0);
    end
    chk_all_perm("R6 unmapped writes");

    // R8: read during write returns old value, then new
    @(negedge clk);
    bus_addr = AW'(64 + 4*2); bus_we = 1'b1; bus_wdata = 32'h0000_0011;
    @(negedge clk);
    chk("R8 old value", bus_rdata, {26'b0, model[2]});
    model[2] = 6'h11 & supp(2);
    chk("R7 same edge", {26'b0, perm_o[12 +: 6]}, {26'b0, model[2]});
    bus_we = 1'b0;
    @(negedge clk);
    chk("R8 new value", bus_rdata, {26'b0, model[2]});

    // R1: reset mid-run clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int n = 0; n < NF; n++) model[n] = '0;
    chk_all_perm("R1 re-reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule